// File: doc/BRIEF.md
# Voltage/Current Conversion Sequencer

This block schedules conversions on one shared 12-bit converter that a two-input multiplexer connects either to a supply-voltage channel or to a current-sense channel. A decoded five-bit command word, written with a one-cycle strobe, sets continuous or single-shot conversion per channel and a range bit for the analog front end. A convert-start pin also requests conversions, so that several monitors can be triggered together.

The sequencer drives the multiplexer select and a one-cycle converter start pulse. It waits a programmable number of clock cycles, the conversion time, and then samples the converter's code into the holding register of the channel that was converted. Per channel it reports whether any result has been stored since reset and whether a single-shot request is still outstanding. A bus front end later uses these two flags to choose between acknowledging with zero data and refusing a read.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, the converter start is low, the select is 0 (voltage), the range output is 0, both holding registers read 0, and both valid flags and both pending flags are 0.
- R2: A command write with bit 1 set raises the voltage pending flag, and one with bit 3 set raises the current pending flag, on the cycle after the write. A later write with those bits at 0 does not cancel a pending request.
- R3: A conversion starts the cycle after the sequencer is idle with a request present. `adc_start` is high for exactly one cycle. `adc_sel` holds its value for the whole conversion. The code on `adc_data` is sampled at the clock edge CONV_CYCLES cycles after the edge that raised `adc_start`.
- R4: A holding register changes only when a conversion of its own channel ends, and it then takes the 12-bit `adc_data` value of that edge. The other register keeps its value.
- R5: A channel's pending flag clears when its result is stored, unless a new request arrives in the same cycle. Its valid flag sets on its first stored result and then stays set until reset.
- R6: When both channels request in the same idle cycle after reset, or after a current conversion, voltage (select 0) is converted first and current (select 1) next.
- R7: Command bit 0 (voltage) and bit 2 (current) select continuous mode. The next conversion starts on the cycle after the previous result is stored, and when both channels are continuous the select alternates on every conversion.
- R8: The convert pin passes through a two-flop synchronizer and acts on its rising edge only. That edge sets the pending flag of each channel that the last command write selected (voltage if bit 0 or bit 1, current if bit 2 or bit 3). A pin held high for many cycles starts only one set of conversions.
- R9: Command bit 4 appears on `range_sel` the cycle after the write and has no effect on the stored codes.
- R10: A rising edge on the convert pin when the last command selected neither channel starts no conversion and sets no pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | One-cycle command write strobe |
| cmd_data | input | 5 | Command word: b0 volt continuous, b1 volt once, b2 current continuous, b3 current once, b4 range |
| conv_pin | input | 1 | Asynchronous convert-start pin |
| adc_data | input | 12 | Converter output code |
| adc_start | output | 1 | One-cycle converter start pulse |
| adc_sel | output | 1 | Multiplexer select: 0 voltage, 1 current |
| range_sel | output | 1 | Range bit to the voltage divider |
| volt_code | output | 12 | Voltage holding register |
| curr_code | output | 12 | Current holding register |
| volt_valid | output | 1 | A voltage result has been stored since reset |
| curr_valid | output | 1 | A current result has been stored since reset |
| volt_pending | output | 1 | Voltage single-shot request outstanding |
| curr_pending | output | 1 | Current single-shot request outstanding |

## Verification
The sequencer is exercised with a single voltage request, a simultaneous request for both channels with the low range set, a request followed at once by a cancelling write, a long convert-pin pulse with one channel selected, a pin pulse with no channel selected, and both channels in continuous mode. The single request shows the start-to-store latency and that the idle register holds its value. The dual request and continuous mode show the voltage-first order and the alternation between channels. The long pulse and the empty selection show edge detection and that the pin has no effect when no channel is selected. The converter code is changed after every start, so a sample taken one cycle off or into the wrong register is caught by the per-cycle comparison against the model.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic {CH_VOLT = 1'b0, CH_CURR = 1'b1} chan_e;
  localparam int CMD_W     = 5;
  localparam int CB_V_CONT = 0;
  localparam int CB_V_ONCE = 1;
  localparam int CB_I_CONT = 2;
  localparam int CB_I_ONCE = 3;
  localparam int CB_RANGE  = 4;
endpackage

// File: rtl/conv_pin_edge.sv
module conv_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  p_single_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/conv_channel.sv
module conv_channel #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_req,
  input  logic         store,
  input  logic [W-1:0] din,
  output logic [W-1:0] result,
  output logic         valid,
  output logic         pending
);
  logic [W-1:0] res_d;
  logic         val_d, pend_d;

  always_comb begin
    res_d  = store ? din : result;
    val_d  = valid | store;
    pend_d = pending;
    if (set_req)    pend_d = 1'b1;
    else if (store) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      valid   <= 1'b0;
      pending <= 1'b0;
    end else begin
      result  <= res_d;
      valid   <= val_d;
      pending <= pend_d;
    end
  end

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> pending);
  p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (store && !set_req) |=> !pending);
  p_valid_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !store |=> $stable(result));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 15000,
  parameter int RES_W       = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             conv_pin,
  input  logic [RES_W-1:0] adc_data,
  output logic             adc_start,
  output logic             adc_sel,
  output logic             range_sel,
  output logic [RES_W-1:0] volt_code,
  output logic [RES_W-1:0] curr_code,
  output logic             volt_valid,
  output logic             curr_valid,
  output logic             volt_pending,
  output logic             curr_pending
);
  localparam int NCH = 2;

  logic             v_cont_q, i_cont_q, v_pin_q, i_pin_q, range_q;
  logic             busy_q, busy_d, start_d;
  chan_e            ch_q, ch_d, last_q, last_d, pick;
  logic             pin_rise, conv_done, go;
  logic [NCH-1:0]   set_v, store_v, pend_v, valid_v, req_v;
  logic [RES_W-1:0] res_v [NCH];

  conv_pin_edge u_pin (.clk(clk), .rst_n(rst_n), .pin(conv_pin), .rise(pin_rise));

  conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(go), .run(busy_q), .done(conv_done));

  assign set_v[0] = (cmd_we & cmd_data[CB_V_ONCE]) | (pin_rise & v_pin_q);
  assign set_v[1] = (cmd_we & cmd_data[CB_I_ONCE]) | (pin_rise & i_pin_q);
  assign req_v[0] = pend_v[0] | v_cont_q;
  assign req_v[1] = pend_v[1] | i_cont_q;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign store_v[g] = conv_done && (ch_q == chan_e'(g));
      conv_channel #(.W(RES_W)) u_ch (
        .clk(clk), .rst_n(rst_n), .set_req(set_v[g]), .store(store_v[g]),
        .din(adc_data), .result(res_v[g]), .valid(valid_v[g]), .pending(pend_v[g]));
    end
  endgenerate

  // Scheduler next state
  always_comb begin
    if (req_v[0] && req_v[1]) pick = (last_q == CH_VOLT) ? CH_CURR : CH_VOLT;
    else if (req_v[0])        pick = CH_VOLT;
    else                      pick = CH_CURR;
    go      = !busy_q && (req_v != '0);
    busy_d  = busy_q;
    ch_d    = ch_q;
    last_d  = last_q;
    if (go) begin
      busy_d = 1'b1;
      ch_d   = pick;
    end else if (conv_done) begin
      busy_d = 1'b0;
      last_d = ch_q;
    end
    start_d = go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      ch_q      <= CH_VOLT;
      last_q    <= CH_CURR;
      adc_start <= 1'b0;
    end else begin
      busy_q    <= busy_d;
      ch_q      <= ch_d;
      last_q    <= last_d;
      adc_start <= start_d;
    end
  end

  // Command register, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_cont_q <= 1'b0;
      i_cont_q <= 1'b0;
      v_pin_q  <= 1'b0;
      i_pin_q  <= 1'b0;
      range_q  <= 1'b0;
    end else if (cmd_we) begin
      v_cont_q <= cmd_data[CB_V_CONT];
      i_cont_q <= cmd_data[CB_I_CONT];
      v_pin_q  <= cmd_data[CB_V_CONT] | cmd_data[CB_V_ONCE];
      i_pin_q  <= cmd_data[CB_I_CONT] | cmd_data[CB_I_ONCE];
      range_q  <= cmd_data[CB_RANGE];
    end
  end

  assign adc_sel      = ch_q;
  assign range_sel    = range_q;
  assign volt_code    = res_v[0];
  assign curr_code    = res_v[1];
  assign volt_valid   = valid_v[0];
  assign curr_valid   = valid_v[1];
  assign volt_pending = pend_v[0];
  assign curr_pending = pend_v[1];

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !conv_done) |=> $stable(adc_sel));
  p_store_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_v));
  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (range_sel == $past(cmd_data[CB_RANGE])));
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  localparam int N = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [4:0]  cmd_data = '0;
  logic        conv_pin = 1'b0;
  logic [11:0] adc_data;
  logic        adc_start, adc_sel, range_sel;
  logic [11:0] volt_code, curr_code;
  logic        volt_valid, curr_valid, volt_pending, curr_pending;

  int errors = 0;
  int checks = 0;
  int starts = 0;
  logic [11:0] v_val = 12'h123;
  logic [11:0] i_val = 12'h456;

  always #5 clk = ~clk;

  assign adc_data = adc_sel ? i_val : v_val;

  conv_sequencer #(.CONV_CYCLES(N)) i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .conv_pin(conv_pin), .adc_data(adc_data), .adc_start(adc_start),
    .adc_sel(adc_sel), .range_sel(range_sel), .volt_code(volt_code),
    .curr_code(curr_code), .volt_valid(volt_valid), .curr_valid(curr_valid),
    .volt_pending(volt_pending), .curr_pending(curr_pending));

  // Behavioural reference model
  bit m_busy, m_ch, m_last, m_start, m_range;
  bit m_vcont, m_icont, m_ven, m_ien, m_vpend, m_ipend, m_vval, m_ival;
  bit p1, p2, p3;
  int m_elapsed;
  logic [11:0] m_vres, m_ires;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ch = 0; m_last = 1; m_start = 0; m_range = 0;
      m_vcont = 0; m_icont = 0; m_ven = 0; m_ien = 0;
      m_vpend = 0; m_ipend = 0; m_vval = 0; m_ival = 0;
      p1 = 0; p2 = 0; p3 = 0; m_elapsed = 0; m_vres = '0; m_ires = '0;
    end else begin
      bit rise, vset, iset, vreq, ireq, fin, go, nxt;
      rise = p2 && !p3;
      p3 = p2; p2 = p1; p1 = conv_pin;
      vset = (cmd_we && cmd_data[1]) || (rise && m_ven);
      iset = (cmd_we && cmd_data[3]) || (rise && m_ien);
      vreq = m_vpend || m_vcont;
      ireq = m_ipend || m_icont;
      fin  = m_busy && (m_elapsed == N - 1);
      go   = !m_busy && (vreq || ireq);
      if (vreq && ireq) nxt = !m_last; else nxt = !vreq;
      if (fin) begin
        if (m_ch == 0) begin m_vres = adc_data; m_vval = 1; m_vpend = 0; end
        else begin m_ires = adc_data; m_ival = 1; m_ipend = 0; end
        m_last = m_ch;
      end
      if (vset) m_vpend = 1;
      if (iset) m_ipend = 1;
      m_start = go;
      if (go) begin m_busy = 1; m_ch = nxt; m_elapsed = 0; end
      else begin
        if (m_busy) m_elapsed++;
        if (fin) m_busy = 0;
      end
      if (cmd_we) begin
        m_vcont = cmd_data[0]; m_icont = cmd_data[2];
        m_ven = cmd_data[0] | cmd_data[1]; m_ien = cmd_data[2] | cmd_data[3];
        m_range = cmd_data[4];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 adc_start", 32'(adc_start), 32'(m_start));
      chk("R6 adc_sel order", 32'(adc_sel), 32'(m_ch));
      chk("R9 range_sel", 32'(range_sel), 32'(m_range));
      chk("R4 volt_code", 32'(volt_code), 32'(m_vres));
      chk("R4 curr_code", 32'(curr_code), 32'(m_ires));
      chk("R5 volt_valid", 32'(volt_valid), 32'(m_vval));
      chk("R5 curr_valid", 32'(curr_valid), 32'(m_ival));
      chk("R2 volt_pending", 32'(volt_pending), 32'(m_vpend));
      chk("R2 curr_pending", 32'(curr_pending), 32'(m_ipend));
      if (adc_start) begin
        starts++;
        v_val = v_val + 12'h111;
        i_val = i_val + 12'h0F1;
      end
    end
  end

  task automatic write_cmd(input logic [4:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_data = d;
    @(negedge clk);
    cmd_we = 1'b0; cmd_data = '0;
  endtask

  task automatic wait_quiet();
    for (int k = 0; k < 200; k++) begin
      if (!m_busy && !m_vpend && !m_ipend && !m_vcont && !m_icont) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    logic [11:0] expv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", 32'(adc_start), 0);
    chk("R1 sel", 32'(adc_sel), 0);
    chk("R1 range", 32'(range_sel), 0);
    chk("R1 codes", 32'({volt_code, curr_code}), 0);
    chk("R1 flags", 32'({volt_valid, curr_valid, volt_pending, curr_pending}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R4: single voltage shot, latency and sampled code
    expv = v_val + 12'h111;
    write_cmd(5'b00010);
    wait_quiet();
    chk("R4 voltage stored", 32'(volt_code), 32'(expv));
    chk("R4 current untouched", 32'(curr_code), 0);
    chk("R5 voltage valid only", 32'({volt_valid, curr_valid}), 32'b10);

    // R6 / R9: both shots with range bit
    write_cmd(5'b11010);
    wait_quiet();
    chk("R9 range set", 32'(range_sel), 1);
    chk("R5 both valid", 32'({volt_valid, curr_valid}), 32'b11);

    // R2: write then cancelling write
    write_cmd(5'b01000);
    write_cmd(5'b00000);
    chk("R2 pending survives zero write", 32'(curr_pending | m_busy), 1);
    wait_quiet();

    // R8: long pin pulse with voltage selected
    write_cmd(5'b00010);
    wait_quiet();
    s0 = starts;
    @(negedge clk); conv_pin = 1'b1;
    repeat (60) @(negedge clk);
    conv_pin = 1'b0;
    wait_quiet();
    chk("R8 one start per pin edge", 32'(starts - s0), 1);

    // R10: pin with nothing selected
    write_cmd(5'b00000);
    s0 = starts;
    @(negedge clk); conv_pin = 1'b1;
    repeat (10) @(negedge clk);
    conv_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 no start", 32'(starts - s0), 0);
    chk("R10 no pending", 32'({volt_pending, curr_pending}), 0);

    // R7: continuous on both channels
    s0 = starts;
    write_cmd(5'b00101);
    repeat (10 * (N + 1)) @(negedge clk);
    chk("R7 continuous restart count", 32'(starts - s0 >= 9), 1);
    write_cmd(5'b00000);
    wait_quiet();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule